// File: doc/BRIEF.md
# Priority trigger arbiter

This block collects trigger requests from ten sources and hands them one at a time to a shared conversion sequencer. Sources 0 to 7 come from the on-chip crossbar. Sources 8 and 9 come from the touch controller. A rising edge on a source's trigger sets a pending flag for that source. When the sequencer is idle, the arbiter picks the pending source with the highest programmed priority. It then raises a one-cycle start pulse with that source's index on the grant output.

Each crossbar source has three controls:
- an enable bit in a mask;
- a 3-bit priority;
- a mode bit that chooses between the hardware trigger and a software strobe.

Touch-controller sources take hardware triggers only. A bypass control takes them out of arbitration and forwards their triggers straight to the converter.

The hand-off to the sequencer works like a valid/ready exchange:
- `start_o` acts as the valid strobe and `seq_busy_i` as the inverse of ready.
- No start is issued in a cycle where busy is sampled high.
- After each start, the arbiter waits one cycle before it issues another. The sequencer therefore has one clock to raise busy.

There is no buffering. A request that is already pending absorbs further edges from the same source until that source is granted.

Top module: `trig_arbiter`

## Requirements
- R1: There are ten sources. Indices 0..7 are crossbar sources and 8..9 are touch sources. `grant_o` carries the 4-bit index of the granted source while `start_o` is high. `grant_o` keeps that value until the next grant. After reset `start_o` and `grant_o` are 0 and no source is pending.
- R2: Among pending, enabled sources, the one with the largest priority wins. The priority of source i is `prio_i[3*i+2:3*i]`, where 7 is highest and 0 is lowest.
- R3: Among pending sources of equal priority, the lowest index wins.
- R4: Crossbar source n is enabled by `xbar_en_i[n]`. A disabled source is never granted. A source that is disabled for even one cycle loses its pending request.
- R5: A crossbar source with `sw_mode_i[n]`=1 takes requests only from `sw_trig_i[n]`, sampled high at a clock edge, and ignores hardware edges. With `sw_mode_i[n]`=0 it takes only rising edges of `hw_trig_i[n]` and ignores the strobe.
- R6: Touch source k (index 8+k) takes only rising edges of `hw_trig_i[8+k]`. It takes part in arbitration only when `touch_en_i[k]`=1 and `touch_bypass_i`=0.
  - With `touch_bypass_i`=1, `touch_direct_o[k]` follows `hw_trig_i[8+k]` combinationally and touch sources are never granted.
  - With `touch_bypass_i`=0, `touch_direct_o` is 0.
- R7: A source yields at most one grant per pending request.
  - A trigger held high produces one request.
  - Further edges that arrive before the grant merge into the same request.
  - An edge that arrives after the grant edge starts a new request.
- R8: A start is issued only at a clock edge where `seq_busy_i` is low and `start_o` is low. `start_o` is therefore never high for two cycles in a row.
- R9: A hardware edge that is present before clock edge k becomes pending at edge k. If the arbiter is idle, `start_o` rises after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_trig_i | input | 10 | Hardware trigger levels; bits 0..7 crossbar, 8..9 touch |
| sw_trig_i | input | 8 | Software trigger strobes for crossbar sources |
| sw_mode_i | input | 8 | 1 selects software trigger for a crossbar source |
| xbar_en_i | input | 8 | Crossbar source enable mask |
| touch_en_i | input | 2 | Touch source enables (used when bypass is 0) |
| touch_bypass_i | input | 1 | 1 forwards touch triggers directly and removes them from arbitration |
| prio_i | input | 30 | Three bits of priority per source, source i at bits 3i+2..3i |
| seq_busy_i | input | 1 | Sequencer busy; no start while high |
| start_o | output | 1 | One-cycle start pulse |
| grant_o | output | 4 | Index of the granted source |
| touch_direct_o | output | 2 | Touch triggers passed through in bypass |

## Verification
The hardest situation to reach from the ports is a request that must be dropped or merged while it waits. Examples are a source that is disabled for a single cycle while its request is pending, and several edges on one source that collapse into one grant. The stimulus reaches these cases by holding `seq_busy_i` high by hand. This freezes the arbiter, so the enables and trigger edges can be changed beneath it before busy is released. A second case is the forced gap after each start when the sequencer never asserts busy. It is reached by driving busy low permanently while two requests are pending.

// File: rtl/trig_arb_pkg.sv
package trig_arb_pkg;

  typedef enum logic {
    SRC_CROSSBAR = 1'b0,
    SRC_TOUCH    = 1'b1
  } src_kind_e;

  // Sources below n_xbar are crossbar inputs, the rest are touch inputs.
  function automatic src_kind_e kind_of(input int unsigned idx, input int unsigned n_xbar);
    return (idx < n_xbar) ? SRC_CROSSBAR : SRC_TOUCH;
  endfunction

endpackage

// File: rtl/trig_src_slot.sv
// One request slot: edge detection, trigger mode select, pending latch.
module trig_src_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_i,
  input  logic sw_i,
  input  logic sw_mode_i,
  input  logic enable_i,
  input  logic take_i,
  output logic req_o
);

  logic hw_q;
  logic pend_q;
  logic rise_w;
  logic event_w;

  assign rise_w  = hw_i & ~hw_q;
  assign event_w = sw_mode_i ? sw_i : rise_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      hw_q <= hw_i;
      if (!enable_i) begin
        pend_q <= 1'b0;
      end else begin
        pend_q <= (pend_q & ~take_i) | event_w;
      end
    end
  end

  assign req_o = pend_q & enable_i;

endmodule

// File: rtl/trig_prio_pick.sv
// Combinational winner selection: highest priority, lowest index on ties.
module trig_prio_pick #(
  parameter int unsigned N      = 10,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [N-1:0]        req_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic                any_o,
  output logic [IDX_W-1:0]    win_o
);

  logic [PRIO_W-1:0] best_p;

  always_comb begin
    any_o  = 1'b0;
    best_p = '0;
    win_o  = '0;
    for (int i = 0; i < N; i++) begin
      // Strict comparison keeps the earlier (lower) index on equal priority.
      if (req_i[i] && (!any_o || (prio_i[i*PRIO_W +: PRIO_W] > best_p))) begin
        any_o  = 1'b1;
        best_p = prio_i[i*PRIO_W +: PRIO_W];
        win_o  = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/trig_grant_ctrl.sv
// Issues the start pulse, holds the grant index, returns the one-hot take.
module trig_grant_ctrl #(
  parameter int unsigned N     = 10,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_i,
  input  logic [IDX_W-1:0] win_i,
  input  logic             busy_i,
  output logic             start_o,
  output logic [IDX_W-1:0] grant_o,
  output logic [N-1:0]     take_o
);

  logic fire_w;

  // One idle cycle after every start gives the sequencer time to raise busy.
  assign fire_w = any_i & ~busy_i & ~start_o;

  always_comb begin
    take_o = '0;
    if (fire_w) begin
      take_o[win_i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o <= 1'b0;
      grant_o <= '0;
    end else begin
      start_o <= fire_w;
      if (fire_w) begin
        grant_o <= win_i;
      end
    end
  end

endmodule

// File: rtl/trig_arbiter.sv
module trig_arbiter
  import trig_arb_pkg::*;
#(
  parameter int unsigned NXBAR  = 8,
  parameter int unsigned NTOUCH = 2,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned NSRC  = NXBAR + NTOUCH,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        hw_trig_i,
  input  logic [NXBAR-1:0]       sw_trig_i,
  input  logic [NXBAR-1:0]       sw_mode_i,
  input  logic [NXBAR-1:0]       xbar_en_i,
  input  logic [NTOUCH-1:0]      touch_en_i,
  input  logic                   touch_bypass_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  input  logic                   seq_busy_i,
  output logic                   start_o,
  output logic [IDX_W-1:0]       grant_o,
  output logic [NTOUCH-1:0]      touch_direct_o
);

  logic [NSRC-1:0]  req_w;
  logic [NSRC-1:0]  take_w;
  logic             any_w;
  logic [IDX_W-1:0] win_w;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic en_w;
    logic sw_w;
    logic mode_w;

    if (kind_of(i, NXBAR) == SRC_CROSSBAR) begin : g_xbar
      assign en_w   = xbar_en_i[i];
      assign sw_w   = sw_trig_i[i];
      assign mode_w = sw_mode_i[i];
    end else begin : g_touch
      // Touch inputs: hardware edge only, and out of arbitration in bypass.
      assign en_w   = touch_en_i[i-NXBAR] & ~touch_bypass_i;
      assign sw_w   = 1'b0;
      assign mode_w = 1'b0;
    end

    trig_src_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_i      (hw_trig_i[i]),
      .sw_i      (sw_w),
      .sw_mode_i (mode_w),
      .enable_i  (en_w),
      .take_i    (take_w[i]),
      .req_o     (req_w[i])
    );
  end

  trig_prio_pick #(
    .N      (NSRC),
    .PRIO_W (PRIO_W),
    .IDX_W  (IDX_W)
  ) u_pick (
    .req_i  (req_w),
    .prio_i (prio_i),
    .any_o  (any_w),
    .win_o  (win_w)
  );

  trig_grant_ctrl #(
    .N     (NSRC),
    .IDX_W (IDX_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_i   (any_w),
    .win_i   (win_w),
    .busy_i  (seq_busy_i),
    .start_o (start_o),
    .grant_o (grant_o),
    .take_o  (take_w)
  );

  assign touch_direct_o = touch_bypass_i ? hw_trig_i[NSRC-1:NXBAR] : '0;

endmodule

// File: rtl/trig_arbiter_chk.sv
module trig_arbiter_chk #(
  parameter int unsigned NXBAR  = 8,
  parameter int unsigned NTOUCH = 2,
  localparam int unsigned NSRC  = NXBAR + NTOUCH,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NXBAR-1:0] xbar_en_i,
  input logic             touch_bypass_i,
  input logic             seq_busy_i,
  input logic             start_o,
  input logic [IDX_W-1:0] grant_o
);

  AST_GRANT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (int'(grant_o) < int'(NSRC))); // R1

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_o |-> $stable(grant_o)); // R1

  AST_MASKED_NEVER_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && (int'(grant_o) < int'(NXBAR))) |->
      ((($past(xbar_en_i)) >> grant_o) & NXBAR'(1)) != '0); // R4

  AST_BYPASS_NO_TOUCH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && (int'(grant_o) >= int'(NXBAR))) |-> !$past(touch_bypass_i)); // R6

  AST_START_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o); // R8

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_o) |-> !$past(seq_busy_i)); // R8

endmodule

bind trig_arbiter trig_arbiter_chk #(
  .NXBAR  (NXBAR),
  .NTOUCH (NTOUCH)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .xbar_en_i      (xbar_en_i),
  .touch_bypass_i (touch_bypass_i),
  .seq_busy_i     (seq_busy_i),
  .start_o        (start_o),
  .grant_o        (grant_o)
);

// File: tb/trig_arbiter_test.sv
`timescale 1ns/1ps
module trig_arbiter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  hw = '0;
  logic [7:0]  sw_trig = '0;
  logic [7:0]  sw_mode = '0;
  logic [7:0]  xen = 8'hFF;
  logic [1:0]  ten = 2'b11;
  logic        byp = 1'b0;
  logic [29:0] prio = '0;
  logic        busy = 1'b0;
  logic        start;
  logic [3:0]  grant;
  logic [1:0]  tdir;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R1";
  bit    auto_busy = 1'b1;
  int    busy_cnt = 0;
  bit    done = 1'b0;

  always #2 clk = ~clk;

  trig_arbiter uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .hw_trig_i      (hw),
    .sw_trig_i      (sw_trig),
    .sw_mode_i      (sw_mode),
    .xbar_en_i      (xen),
    .touch_en_i     (ten),
    .touch_bypass_i (byp),
    .prio_i         (prio),
    .seq_busy_i     (busy),
    .start_o        (start),
    .grant_o        (grant),
    .touch_direct_o (tdir)
  );

  // ---------------- behavioural reference model ----------------
  logic [9:0] m_prev, m_pend;
  logic       m_start;
  int         m_grant;
  int         win, bp;
  logic       take;

  function automatic bit src_en(int i);
    if (i < 8) return xen[i];
    return ten[i-8] && !byp;
  endfunction

  function automatic bit src_event(int i);
    bit rise;
    rise = hw[i] && !m_prev[i];
    if (i < 8 && sw_mode[i]) return sw_trig[i];
    return rise;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = '0; m_pend = '0; m_start = 1'b0; m_grant = 0;
    end else begin
      win = -1; bp = -1;
      for (int i = 0; i < 10; i++) begin
        if (m_pend[i] && src_en(i) && int'(prio[3*i +: 3]) > bp) begin
          bp = int'(prio[3*i +: 3]);
          win = i;
        end
      end
      take = (win >= 0) && !busy && !m_start;
      for (int i = 0; i < 10; i++) begin
        if (!src_en(i)) m_pend[i] = 1'b0;
        else m_pend[i] = (m_pend[i] && !(take && win == i)) || src_event(i);
      end
      m_prev = hw;
      m_start = take;
      if (take) m_grant = win;
    end
  end

  // Cycle-by-cycle comparison, sampled 1 ns after the rising edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      n_tests++;
      if (start !== m_start) begin
        n_fail++;
        $display("FAIL %s: start_o=%0b expected %0b", cur_req, start, m_start);
      end
      n_tests++;
      if (grant !== 4'(m_grant)) begin
        n_fail++;
        $display("FAIL %s: grant_o=%0d expected %0d", cur_req, grant, m_grant);
      end
      n_tests++;
      if (tdir !== (byp ? hw[9:8] : 2'b00)) begin
        n_fail++;
        $display("FAIL R6: touch_direct_o=%b expected %b", tdir, (byp ? hw[9:8] : 2'b00));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(negedge clk);
    if (auto_busy) begin
      if (busy_cnt > 0) begin
        busy_cnt--;
        busy = (busy_cnt != 0);
      end else if (start) begin
        busy_cnt = 3;
        busy = 1'b1;
      end
    end
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_hw(logic [9:0] m);
    hw = hw | m;
    step();
    hw = hw & ~m;
    step();
  endtask

  task automatic pulse_sw(logic [7:0] m);
    sw_trig = sw_trig | m;
    step();
    sw_trig = sw_trig & ~m;
    step();
  endtask

  task automatic wait_grant(int exp, string req);
    bit seen;
    seen = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (start) begin seen = 1'b1; break; end
      step();
    end
    check(seen, req, 0, 1);
    check(int'(grant) == exp, req, int'(grant), exp);
    step();
  endtask

  task automatic count_starts(int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      if (start) c++;
      step();
    end
  endtask

  task automatic expect_idle(int n, string req);
    int c;
    count_starts(n, c);
    check(c == 0, req, c, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    int c;
    for (int k = 0; k < 5; k++) @(negedge clk);
    cur_req = "R1";
    check(start === 1'b0, "R1 reset start_o", int'(start), 0);
    check(grant === 4'd0, "R1 reset grant_o", int'(grant), 0);
    rst_n = 1'b1;
    step(); step();

    // R1: single crossbar source
    cur_req = "R1";
    pulse_hw(10'b00_0000_1000);
    wait_grant(3, "R1");
    expect_idle(6, "R1");

    // R2: priority order
    cur_req = "R2";
    prio[3*2 +: 3] = 3'd5;
    prio[3*6 +: 3] = 3'd7;
    pulse_hw(10'b00_0100_0100);
    wait_grant(6, "R2");
    wait_grant(2, "R2");

    // R3: equal priority, lowest index first
    cur_req = "R3";
    prio = '0;
    prio[3*1 +: 3] = 3'd4;
    prio[3*4 +: 3] = 3'd4;
    pulse_hw(10'b00_0001_0010);
    wait_grant(1, "R3");
    wait_grant(4, "R3");
    prio = '0;

    // R4: masked source ignored; pending dropped by a one-cycle disable
    cur_req = "R4";
    xen[5] = 1'b0;
    pulse_hw(10'b00_0010_0000);
    expect_idle(8, "R4");
    auto_busy = 1'b0; busy = 1'b1;
    pulse_hw(10'b00_0000_0001);
    xen[0] = 1'b0; step();
    xen[0] = 1'b1; busy = 1'b0;
    expect_idle(8, "R4");
    auto_busy = 1'b1; xen[5] = 1'b1;

    // R9: latency from edge to start
    cur_req = "R9";
    hw[5] = 1'b1;
    step();
    check(start === 1'b0, "R9 one edge after", int'(start), 0);
    step();
    check(start === 1'b1, "R9 two edges after", int'(start), 1);
    check(int'(grant) == 5, "R9 grant", int'(grant), 5);
    hw[5] = 1'b0;
    step(); step(); step(); step(); step();

    // R5: software mode
    cur_req = "R5";
    sw_mode[7] = 1'b1;
    pulse_hw(10'b00_1000_0000);
    expect_idle(6, "R5");
    pulse_sw(8'h80);
    wait_grant(7, "R5");
    pulse_sw(8'h01);
    expect_idle(6, "R5");
    sw_mode[7] = 1'b0;

    // R6: touch sources and bypass
    cur_req = "R6";
    pulse_hw(10'b10_0000_0000);
    wait_grant(9, "R6");
    step(); step(); step();
    byp = 1'b1;
    hw[8] = 1'b1;
    step();
    check(tdir === 2'b01, "R6 direct", int'(tdir), 1);
    hw[8] = 1'b0;
    expect_idle(6, "R6");
    byp = 1'b0;
    step();
    check(tdir === 2'b00, "R6 no direct", int'(tdir), 0);
    ten[1] = 1'b0;
    pulse_hw(10'b10_0000_0000);
    expect_idle(6, "R6");
    ten[1] = 1'b1;

    // R7: held level gives one grant; repeated edges merge
    cur_req = "R7";
    hw[2] = 1'b1;
    count_starts(15, c);
    check(c == 1, "R7 held level", c, 1);
    hw[2] = 1'b0; step();
    auto_busy = 1'b0; busy = 1'b1;
    pulse_hw(10'b00_0000_0100);
    pulse_hw(10'b00_0000_0100);
    pulse_hw(10'b00_0000_0100);
    busy = 1'b0;
    count_starts(10, c);
    check(c == 1, "R7 merged edges", c, 1);

    // R8: busy blocks grants; gap after every start
    cur_req = "R8";
    busy = 1'b1;
    pulse_hw(10'b00_0000_0010);
    expect_idle(6, "R8");
    busy = 1'b0;
    wait_grant(1, "R8");
    pulse_hw(10'b00_0001_1000);
    for (int k = 0; k < 10 && !start; k++) step();
    check(start === 1'b1 && grant == 4'd3, "R8 first", int'(grant), 3);
    step();
    check(start === 1'b0, "R8 gap", int'(start), 0);
    step();
    check(start === 1'b1 && grant == 4'd4, "R8 second", int'(grant), 4);
    step(); step();
    auto_busy = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule